// File: doc/BRIEF.md
# Configurable Asynchronous Serial Framer

This block pairs a serial transmitter with a serial receiver. Both follow one frame setup: a parity bit can be on or off, parity can be even or odd, and the transmitter can send one or two stop bits. The transmitter accepts a byte over a valid/ready handshake. It then drives the line through a low start bit, the eight data bits with the least significant bit first, an optional parity bit, and one or two high stop bits.

The receiver samples the incoming line at sixteen times the bit rate, paced by the `tickEn` input. It hands back each byte as a one-clock pulse, with a flag for a parity mismatch and a flag for a bad stop bit. The receiver looks at the first stop bit only. After a good first stop bit it is idle again at once, so a line that falls during a second stop-bit slot starts the next character with no error.

Each side latches the frame setup when a character begins. A setup change in the middle of a character therefore affects only later characters.

Top module: `serial_framer`

## Requirements
- R1: After reset `txLine` is high, `txReady` is high and `rxValid` is low. While the transmitter is idle, the line stays high.
- R2: A byte is taken on a clock where `txValid` and `txReady` are both high, and `txReady` stays low until the frame ends. The frame starts with one low bit, followed by the eight data bits least significant bit first. Each bit lasts 16 `tickEn` pulses.
- R3: When `cfgParityOn` is 1, a parity bit follows the data. With `cfgParityOdd` = 0 (even) it makes the count of ones in data plus parity even. With `cfgParityOdd` = 1 (odd) it makes that count odd. When `cfgParityOn` is 0, no parity bit is sent.
- R4: With `cfgTwoStop` = 0 one high stop bit is sent, and with 1 two are sent. `txReady` rises on the 16*N-th tick after acceptance, where N is the total number of bits in the frame.
- R5: The receiver takes a low line seen on a tick as a start candidate. It confirms the candidate 8 ticks later and samples each following bit 16 ticks after the previous sample. It delivers the byte on `rxData` with `rxValid` high for exactly one clock.
- R6: With parity on, `rxParityErr` is 1 when the count of ones in data plus received parity is odd under even sense, or even under odd sense. With parity off, no parity slot is expected and the flag stays 0.
- R7: If the first stop bit samples low, `rxFrameErr` is 1 and the byte is still delivered. The error flags are only ever high together with `rxValid`.
- R8: The receiver checks only the first stop bit, whatever `cfgTwoStop` is set to. A low line directly after a good first stop bit is received as the start of the next character.
- R9: A low pulse that is high again at the start-confirm sample is ignored. After a low first stop bit, no new character starts until the line has been high.
- R10: The frame setup is latched at the start of each transmitted and each received character. Changing it during a character has no effect on that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Oversample enable, 16 pulses per bit time |
| cfgParityOn | input | 1 | 1 adds and checks a parity bit |
| cfgParityOdd | input | 1 | Parity sense: 0 even, 1 odd |
| cfgTwoStop | input | 1 | Transmitter stop bits: 0 one, 1 two |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | `txData` is offered |
| txReady | output | 1 | Transmitter idle, can accept a byte |
| txLine | output | 1 | Serial output, idles high |
| rxLine | input | 1 | Serial input, asynchronous |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | One-clock pulse when a byte arrives |
| rxParityErr | output | 1 | Parity mismatch, valid with `rxValid` |
| rxFrameErr | output | 1 | First stop bit was low, valid with `rxValid` |

## Verification
The properties assume that `tickEn` is much slower than the clock relative to a bit time. With 16 ticks per bit, two receive-complete strobes can never fall on adjacent clocks. They also assume that `txValid` only counts when `txReady` is high. The bench stays within these limits. It raises `tickEn` on every other clock, holds each received bit for exactly 16 ticks, and changes every input at a falling clock edge, so the receiver sees clean, synchronised levels.

// File: rtl/framer_pkg.sv
package framer_pkg;

  // Frame setup as seen at the pins
  typedef struct packed {
    logic parityOn;
    logic parityOdd;
    logic twoStop;
  } frameCfg_t;

  // What the transmit line register should drive next
  typedef enum logic [1:0] {
    LINE_MARK   = 2'd0,
    LINE_SPACE  = 2'd1,
    LINE_DATA   = 2'd2,
    LINE_PARITY = 2'd3
  } lineSel_t;

  // Control to datapath strobes
  typedef struct packed {
    logic     txLoad;
    logic     txShift;
    lineSel_t txLineSel;
    logic     rxStart;
    logic     rxShift;
    logic     rxParity;
    logic     rxDone;
  } strobes_t;

endpackage

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import framer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tickEn,
  input  logic     txValid,
  input  logic     rxBit,
  input  logic     txParityOn,
  input  logic     txTwoStop,
  input  logic     rxParityOn,
  output logic     txReady,
  output strobes_t strobes
);

  localparam int TICK_W = $clog2(OSR);
  localparam int BIT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(OSR - 1);
  localparam logic [TICK_W-1:0] TICK_MID  = TICK_W'(OSR / 2 - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(DATA_W - 1);

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP1, TX_STOP2
  } txState_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP
  } rxState_t;

  txState_t          txState;
  logic [TICK_W-1:0] txCnt;
  logic [BIT_W-1:0]  txIdx;
  logic              txBitEnd;

  rxState_t          rxState;
  logic [TICK_W-1:0] rxCnt;
  logic [BIT_W-1:0]  rxIdx;
  logic              rxArmed;
  logic              rxSample;

  // ---------------- transmit sequencing ----------------
  always_comb begin
    txReady  = (txState == TX_IDLE);
    txBitEnd = tickEn && (txCnt == TICK_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txCnt   <= '0;
      txIdx   <= '0;
    end else if (txState == TX_IDLE) begin
      if (txValid) begin
        txState <= TX_START;
        txCnt   <= '0;
        txIdx   <= '0;
      end
    end else if (tickEn) begin
      if (txCnt == TICK_LAST) begin
        txCnt <= '0;
        case (txState)
          TX_START:  txState <= TX_DATA;
          TX_DATA: begin
            if (txIdx == BIT_LAST) txState <= txParityOn ? TX_PARITY : TX_STOP1;
            else                   txIdx   <= txIdx + 1'b1;
          end
          TX_PARITY: txState <= TX_STOP1;
          TX_STOP1:  txState <= txTwoStop ? TX_STOP2 : TX_IDLE;
          default:   txState <= TX_IDLE;
        endcase
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  // ---------------- receive sequencing ----------------
  always_comb begin
    if (rxState == RX_START) rxSample = tickEn && (rxCnt == TICK_MID);
    else                     rxSample = tickEn && (rxCnt == TICK_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxIdx   <= '0;
      rxArmed <= 1'b0;
    end else if (rxState == RX_IDLE) begin
      if (rxBit) begin
        rxArmed <= 1'b1;
      end else if (tickEn && rxArmed) begin
        rxState <= RX_START;
        rxCnt   <= '0;
        rxIdx   <= '0;
        rxArmed <= 1'b0;
      end
    end else if (tickEn) begin
      if (rxSample) begin
        rxCnt <= '0;
        case (rxState)
          RX_START: rxState <= rxBit ? RX_IDLE : RX_DATA;
          RX_DATA: begin
            if (rxIdx == BIT_LAST) rxState <= rxParityOn ? RX_PARITY : RX_STOP;
            else                   rxIdx   <= rxIdx + 1'b1;
          end
          RX_PARITY: rxState <= RX_STOP;
          default: begin
            // only the first stop bit is looked at; idle right after it
            rxState <= RX_IDLE;
            rxArmed <= rxBit;
          end
        endcase
      end else begin
        rxCnt <= rxCnt + 1'b1;
      end
    end
  end

  // ---------------- strobes ----------------
  always_comb begin
    strobes         = '0;
    strobes.txLoad  = txReady && txValid;
    strobes.txShift = (txState == TX_DATA) && txBitEnd;
    case (txState)
      TX_START:  strobes.txLineSel = LINE_SPACE;
      TX_DATA:   strobes.txLineSel = LINE_DATA;
      TX_PARITY: strobes.txLineSel = LINE_PARITY;
      default:   strobes.txLineSel = LINE_MARK;
    endcase
    strobes.rxStart  = (rxState == RX_IDLE) && tickEn && rxArmed && !rxBit;
    strobes.rxShift  = (rxState == RX_DATA) && rxSample;
    strobes.rxParity = (rxState == RX_PARITY) && rxSample;
    strobes.rxDone   = (rxState == RX_STOP) && rxSample;
  end

endmodule

// File: rtl/framer_dpath.sv
module framer_dpath
  import framer_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  frameCfg_t         cfgIn,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxLine,
  output logic              txLine,
  output logic              rxBit,
  output logic              txParityOn,
  output logic              txTwoStop,
  output logic              rxParityOn,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxParityErr,
  output logic              rxFrameErr
);

  logic [DATA_W-1:0] txShiftReg;
  logic              txParBit;
  logic [DATA_W-1:0] rxShiftReg;
  logic              rxParBit;
  logic              rxParityOdd;

  // ---------------- input synchroniser ----------------
  generate
    if (SYNC_STAGES > 1) begin : g_syncChain
      logic [SYNC_STAGES-1:0] syncReg;
      always_ff @(posedge clk) begin
        if (!rstN) syncReg <= '1;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], rxLine};
      end
      assign rxBit = syncReg[SYNC_STAGES-1];
    end else begin : g_syncSingle
      logic syncReg;
      always_ff @(posedge clk) begin
        if (!rstN) syncReg <= 1'b1;
        else       syncReg <= rxLine;
      end
      assign rxBit = syncReg;
    end
  endgenerate

  // ---------------- transmit datapath ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShiftReg <= '0;
      txParBit   <= 1'b0;
      txParityOn <= 1'b0;
      txTwoStop  <= 1'b0;
    end else if (strobes.txLoad) begin
      txShiftReg <= txData;
      txParBit   <= (^txData) ^ cfgIn.parityOdd;
      txParityOn <= cfgIn.parityOn;
      txTwoStop  <= cfgIn.twoStop;
    end else if (strobes.txShift) begin
      txShiftReg <= {1'b0, txShiftReg[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txLine <= 1'b1;
    end else begin
      case (strobes.txLineSel)
        LINE_SPACE:  txLine <= 1'b0;
        LINE_DATA:   txLine <= txShiftReg[0];
        LINE_PARITY: txLine <= txParBit;
        default:     txLine <= 1'b1;
      endcase
    end
  end

  // ---------------- receive datapath ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShiftReg  <= '0;
      rxParBit    <= 1'b0;
      rxParityOn  <= 1'b0;
      rxParityOdd <= 1'b0;
    end else begin
      if (strobes.rxStart) begin
        rxParityOn  <= cfgIn.parityOn;
        rxParityOdd <= cfgIn.parityOdd;
      end
      if (strobes.rxShift)  rxShiftReg <= {rxBit, rxShiftReg[DATA_W-1:1]};
      if (strobes.rxParity) rxParBit   <= rxBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData      <= '0;
      rxValid     <= 1'b0;
      rxParityErr <= 1'b0;
      rxFrameErr  <= 1'b0;
    end else if (strobes.rxDone) begin
      rxData      <= rxShiftReg;
      rxValid     <= 1'b1;
      rxParityErr <= rxParityOn & ((^rxShiftReg) ^ rxParBit ^ rxParityOdd);
      rxFrameErr  <= ~rxBit;
    end else begin
      rxValid     <= 1'b0;
      rxParityErr <= 1'b0;
      rxFrameErr  <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_framer.sv
module serial_framer
  import framer_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              cfgParityOn,
  input  logic              cfgParityOdd,
  input  logic              cfgTwoStop,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic              txLine,
  input  logic              rxLine,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxParityErr,
  output logic              rxFrameErr
);

  frameCfg_t cfgIn;
  strobes_t  strobes;
  logic      rxBit;
  logic      txParityOn;
  logic      txTwoStop;
  logic      rxParityOn;

  assign cfgIn = '{parityOn: cfgParityOn, parityOdd: cfgParityOdd, twoStop: cfgTwoStop};

  framer_ctrl #(.DATA_W(DATA_W), .OSR(OSR)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .txValid    (txValid),
    .rxBit      (rxBit),
    .txParityOn (txParityOn),
    .txTwoStop  (txTwoStop),
    .rxParityOn (rxParityOn),
    .txReady    (txReady),
    .strobes    (strobes)
  );

  framer_dpath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .cfgIn       (cfgIn),
    .txData      (txData),
    .rxLine      (rxLine),
    .txLine      (txLine),
    .rxBit       (rxBit),
    .txParityOn  (txParityOn),
    .txTwoStop   (txTwoStop),
    .rxParityOn  (rxParityOn),
    .rxData      (rxData),
    .rxValid     (rxValid),
    .rxParityErr (rxParityErr),
    .rxFrameErr  (rxFrameErr)
  );

endmodule

// File: rtl/serial_framer_checker.sv
module serial_framer_checker (
  input logic clk,
  input logic rstN,
  input logic tickEn,
  input logic txValid,
  input logic txReady,
  input logic txLine,
  input logic rxValid,
  input logic rxParityErr,
  input logic rxFrameErr
);

  // R1: an idle transmitter holds the line at mark
  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txLine);

  // R2: ready only drops after a byte was offered
  assert_accept_on_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txReady) |-> $past(txValid));

  // R2: the line moves only as a result of a tick or an accepted byte
  assert_line_paced_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txLine) |-> ($past(tickEn, 2) || $past(txValid && txReady, 2)));

  // R4: a frame can only finish on a tick
  assert_frame_ends_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReady) |-> $past(tickEn));

  // R5: one clock per delivered byte
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R7: error flags travel with the byte
  assert_flags_with_byte_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxParityErr || rxFrameErr) |-> rxValid);

endmodule

bind serial_framer serial_framer_checker i_checker (
  .clk         (clk),
  .rstN        (rstN),
  .tickEn      (tickEn),
  .txValid     (txValid),
  .txReady     (txReady),
  .txLine      (txLine),
  .rxValid     (rxValid),
  .rxParityErr (rxParityErr),
  .rxFrameErr  (rxFrameErr)
);

// File: tb/test_serial_framer.sv
`timescale 1ns/1ps
module test_serial_framer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       cfgParityOn = 1'b0;
  logic       cfgParityOdd = 1'b0;
  logic       cfgTwoStop = 1'b0;
  logic [7:0] txData = '0;
  logic       txValid = 1'b0;
  logic       txReady;
  logic       txLine;
  logic       rxLine = 1'b1;
  logic [7:0] rxData;
  logic       rxValid;
  logic       rxParityErr;
  logic       rxFrameErr;

  int checks = 0;
  int errors = 0;
  int tickCount = 0;

  logic [7:0] capData [0:31];
  bit         capPerr [0:31];
  bit         capFerr [0:31];
  int         capCount = 0;

  serial_framer i_serial_framer (
    .clk         (clk),
    .rstN        (rstN),
    .tickEn      (tickEn),
    .cfgParityOn (cfgParityOn),
    .cfgParityOdd(cfgParityOdd),
    .cfgTwoStop  (cfgTwoStop),
    .txData      (txData),
    .txValid     (txValid),
    .txReady     (txReady),
    .txLine      (txLine),
    .rxLine      (rxLine),
    .rxData      (rxData),
    .rxValid     (rxValid),
    .rxParityErr (rxParityErr),
    .rxFrameErr  (rxFrameErr)
  );

  // 200 MHz
  initial forever #2.5 clk = ~clk;

  // tick on every other clock, changed away from the active edge
  initial forever begin
    @(negedge clk);
    tickEn = ~tickEn;
  end

  always @(posedge clk) if (tickEn) tickCount <= tickCount + 1;

  always @(negedge clk) begin
    if (rxValid && capCount < 32) begin
      capData[capCount] = rxData;
      capPerr[capCount] = rxParityErr;
      capFerr[capCount] = rxFrameErr;
      capCount = capCount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitTickAbs(input int n);
    while (tickCount < n) @(negedge clk);
  endtask

  // ---------------- transmit scenarios ----------------
  task automatic txFrame(input logic [7:0] d, input bit parOn, input bit odd,
                         input bit two, input bit flipMid);
    int base;
    int nb;
    bit expBits [0:11];
    string tag;
    cfgParityOn  = parOn;
    cfgParityOdd = odd;
    cfgTwoStop   = two;
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txData  = d;
    txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    base = tickCount;
    check(txReady == 1'b0, "R2", "ready low after accept", txReady, 0);
    if (flipMid) begin
      cfgParityOn  = ~parOn;
      cfgParityOdd = ~odd;
      cfgTwoStop   = ~two;
    end
    nb = 0;
    expBits[nb] = 1'b0; nb = nb + 1;
    for (int i = 0; i < 8; i++) begin expBits[nb] = d[i]; nb = nb + 1; end
    if (parOn) begin expBits[nb] = (^d) ^ odd; nb = nb + 1; end
    expBits[nb] = 1'b1; nb = nb + 1;
    if (two) begin expBits[nb] = 1'b1; nb = nb + 1; end
    for (int k = 0; k < nb; k++) begin
      waitTickAbs(base + 8 + 16 * k);
      if (flipMid)                tag = "R10";
      else if (k < 9)             tag = "R2";
      else if (parOn && k == 9)   tag = "R3";
      else                        tag = "R4";
      check(txLine == expBits[k], tag, $sformatf("tx bit slot %0d", k),
            txLine, expBits[k]);
    end
    waitTickAbs(base + 16 * nb - 1);
    check(txReady == 1'b0, flipMid ? "R10" : "R4", "ready before frame end", txReady, 0);
    waitTickAbs(base + 16 * nb);
    check(txReady == 1'b1, flipMid ? "R10" : "R4", "ready at frame end", txReady, 1);
    check(txLine == 1'b1, "R1", "line idles high", txLine, 1);
  endtask

  // ---------------- receive driver ----------------
  task automatic rxSendFrame(input logic [7:0] d, input bit parOn, input bit odd,
                             input bit flipPar, input bit stop1,
                             input bit flipCfgMid, input int idleTicks);
    int t;
    @(negedge clk);
    rxLine = 1'b0;
    t = tickCount + 16;
    waitTickAbs(t);
    for (int i = 0; i < 8; i++) begin
      rxLine = d[i];
      if (flipCfgMid && i == 3) cfgParityOn = ~cfgParityOn;
      t = t + 16;
      waitTickAbs(t);
    end
    if (parOn) begin
      rxLine = (^d) ^ odd ^ flipPar;
      t = t + 16;
      waitTickAbs(t);
    end
    rxLine = stop1;
    t = t + 16;
    waitTickAbs(t);
    rxLine = 1'b1;
    t = t + idleTicks;
    waitTickAbs(t);
  endtask

  task automatic rxExpect(input int idx, input logic [7:0] d, input bit pe,
                          input bit fe, input string req);
    check(capCount > idx, req, "byte delivered", capCount, idx + 1);
    if (capCount > idx) begin
      check(capData[idx] == d, req, "rx data", capData[idx], d);
      check(capPerr[idx] == pe, req, "parity flag", capPerr[idx], pe);
      check(capFerr[idx] == fe, req, "framing flag", capFerr[idx], fe);
    end
  endtask

  // ---------------- receive scenarios ----------------
  task automatic rxBasic();
    int idx;
    cfgParityOn = 0; cfgParityOdd = 0; cfgTwoStop = 0;
    idx = capCount;
    rxSendFrame(8'h5A, 0, 0, 0, 1, 0, 24);
    rxExpect(idx, 8'h5A, 0, 0, "R5");
    check(capCount == idx + 1, "R5", "exactly one byte", capCount, idx + 1);
  endtask

  task automatic rxParity();
    int idx;
    cfgParityOn = 1; cfgParityOdd = 0;
    idx = capCount;
    rxSendFrame(8'h07, 1, 0, 0, 1, 0, 24);
    rxExpect(idx, 8'h07, 0, 0, "R6");
    rxSendFrame(8'h07, 1, 0, 1, 1, 0, 24);
    rxExpect(idx + 1, 8'h07, 1, 0, "R6");
    cfgParityOdd = 1;
    rxSendFrame(8'hC3, 1, 1, 0, 1, 0, 24);
    rxExpect(idx + 2, 8'hC3, 0, 0, "R6");
    rxSendFrame(8'hC3, 1, 1, 1, 1, 0, 24);
    rxExpect(idx + 3, 8'hC3, 1, 0, "R6");
    cfgParityOn = 0;
  endtask

  task automatic rxFraming();
    int idx;
    cfgParityOn = 0; cfgTwoStop = 0;
    idx = capCount;
    rxSendFrame(8'h99, 0, 0, 0, 0, 0, 40);
    rxExpect(idx, 8'h99, 0, 1, "R7");
    check(capCount == idx + 1, "R7", "single delivery on framing error", capCount, idx + 1);
  endtask

  task automatic rxBackToBack();
    int idx;
    cfgParityOn = 0; cfgTwoStop = 1;
    idx = capCount;
    rxSendFrame(8'h81, 0, 0, 0, 1, 0, 0);
    rxSendFrame(8'h42, 0, 0, 0, 1, 0, 40);
    rxExpect(idx, 8'h81, 0, 0, "R8");
    rxExpect(idx + 1, 8'h42, 0, 0, "R8");
    cfgTwoStop = 0;
  endtask

  task automatic rxFalseStart();
    int idx;
    int t;
    cfgParityOn = 0;
    idx = capCount;
    @(negedge clk);
    rxLine = 1'b0;
    t = tickCount + 4;
    waitTickAbs(t);
    rxLine = 1'b1;
    waitTickAbs(t + 200);
    check(capCount == idx, "R9", "glitch ignored", capCount, idx);
    rxSendFrame(8'h3E, 0, 0, 0, 1, 0, 24);
    rxExpect(idx, 8'h3E, 0, 0, "R9");
  endtask

  task automatic rxBreak();
    int idx;
    int t;
    cfgParityOn = 0;
    idx = capCount;
    rxSendFrame(8'h66, 0, 0, 0, 0, 0, 0);
    rxLine = 1'b0;
    t = tickCount + 200;
    waitTickAbs(t);
    rxLine = 1'b1;
    waitTickAbs(t + 40);
    rxExpect(idx, 8'h66, 0, 1, "R9");
    check(capCount == idx + 1, "R9", "no restart while line stays low", capCount, idx + 1);
  endtask

  task automatic rxCfgHold();
    int idx;
    cfgParityOn = 1; cfgParityOdd = 0;
    idx = capCount;
    // 0x03 has even parity bit 0: a receiver that dropped the parity slot
    // would take it for a low stop bit
    rxSendFrame(8'h03, 1, 0, 0, 1, 1, 24);
    rxExpect(idx, 8'h03, 0, 0, "R10");
    cfgParityOn = 0;
  endtask

  // ---------------- sequence ----------------
  initial begin
    repeat (10) @(negedge clk);
    check(txLine == 1'b1, "R1", "tx line in reset", txLine, 1);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(txLine == 1'b1, "R1", "tx line after reset", txLine, 1);
    check(txReady == 1'b1, "R1", "ready after reset", txReady, 1);
    check(rxValid == 1'b0, "R1", "no rx pulse after reset", rxValid, 0);

    txFrame(8'hA5, 0, 0, 0, 0);
    txFrame(8'h3C, 1, 0, 1, 0);
    txFrame(8'h01, 1, 1, 0, 0);
    txFrame(8'h00, 1, 1, 1, 0);
    txFrame(8'hF7, 1, 0, 0, 0);
    txFrame(8'h6D, 0, 0, 0, 1);

    rxBasic();
    rxParity();
    rxFraming();
    rxBackToBack();
    rxFalseStart();
    rxBreak();
    rxCfgHold();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule